// File: doc/BRIEF.md
# Vectored Interrupt Collector

This block gathers a parameterised set of peripheral request lines (up to 32) and turns them into one vectored IRQ line and one fast-interrupt (FIQ) line for a processor. Each source owns a small configuration word with a priority, an enable and a steer-to-FIQ flag. Among the enabled sources that are requesting and are not steered to FIQ, the one with the highest priority wins. On a tie the lowest index wins. The vector register then reads as a software-programmed table base plus four times the winner's index, so the handler address can be fetched straight from a table.

Software services an interrupt in two steps. It first writes the vector register, which marks entry to the routine: the winner is frozen and IRQ drops. It then writes a level-acknowledge register, which ends the service and lets the next pending source raise IRQ again. A master enable bit in the control register gates the IRQ output. A soft-reset bit in the same register zeroes every source configuration. Every source word can be rewritten whole, or changed bit by bit through set and clear aliases.

Top module: `irq_vector_hub`

## Requirements
- R1: After rst_n is released, every source word reads 0, the control register reads 0, and irq_o and fiq_o are low.
- R2: Source i has its word at byte address 0x100+16*i. Bits [PRIO_W-1:0] hold the priority, bit 4 the enable and bit 5 the steer-to-FIQ flag. A write at offset 0 replaces the word, and all other bits read as 0.
- R3: A write at offset 4 of a source word sets the bits written as 1. A write at offset 8 clears the bits written as 1. All other bits of the word keep their value.
- R4: irq_o is high exactly when control bit 0 (the master enable, address 0x000) is 1, some enabled source not steered to FIQ is requesting, and no service is open. A source whose enable bit is 0 has no effect.
- R5: A read of the vector register (0x008) returns the base register (0x004) plus 4 times the selected source index.
- R6: The selected source is the requesting, enabled, IRQ-routed source with the largest priority value. Among equal priorities the lowest index wins.
- R7: A write to the vector register while a source is selectable opens a service: irq_o is low from the next cycle, and the vector keeps the index chosen in the write cycle until the service closes, whatever the request lines do.
- R8: A write to the acknowledge register (0x00C) with bit 0 set closes the service, and irq_o returns the cycle after if a source is still pending. A write with bit 0 clear has no effect.
- R9: A source steered to FIQ that is enabled and requesting drives fiq_o high, and it is never chosen for irq_o or the vector.
- R10: A control write with bit 31 set zeroes every source word and closes any open service. Bit 31 always reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Level request per source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Vectored interrupt to processor |
| fiq_o | output | 1 | Fast interrupt to processor |

## Verification
The entry write to the vector register can land in the same cycle as a new, higher-priority request rising. The bench provokes this by raising that source's request line at the same clock edge that carries the entry write. It then requires the frozen vector to name the newcomer and not the source that was shown before the edge. The bench also holds a service open while it drops request lines and changes priorities, and it checks that the frozen vector does not move.

// File: rtl/ivh_pkg.sv
package ivh_pkg;
   localparam int CFG_W   = 6;
   localparam int EN_BIT  = 4;
   localparam int FIQ_BIT = 5;
   localparam int ADR_W   = 12;

   localparam logic [ADR_W-1:0] ADR_CTRL = 12'h000;
   localparam logic [ADR_W-1:0] ADR_BASE = 12'h004;
   localparam logic [ADR_W-1:0] ADR_VECT = 12'h008;
   localparam logic [ADR_W-1:0] ADR_ACK  = 12'h00C;
   localparam logic [ADR_W-1:0] ADR_SRC0 = 12'h100;

   typedef enum logic [1:0] {
      CFG_WRITE = 2'd0,
      CFG_SET   = 2'd1,
      CFG_CLR   = 2'd2,
      CFG_NONE  = 2'd3
   } cfg_op_e;

   typedef enum logic {
      SV_IDLE = 1'b0,
      SV_BUSY = 1'b1
   } svc_e;
endpackage

// File: rtl/ivh_src_bank.sv
module ivh_src_bank
   import ivh_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 2,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      srst,
   input  cfg_op_e                   wr_op,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [CFG_W-1:0]          wr_data,
   input  logic [IDX_W-1:0]          rd_idx,
   output logic [CFG_W-1:0]          rd_cfg,
   output logic [NUM_SRC-1:0]        en_o,
   output logic [NUM_SRC-1:0]        fiq_o,
   output logic [NUM_SRC*PRIO_W-1:0] prio_o
);
   localparam logic [CFG_W-1:0] FIELD_MASK =
      CFG_W'((1 << EN_BIT) | (1 << FIQ_BIT) | ((1 << PRIO_W) - 1));

   logic [CFG_W-1:0] cfg_q [NUM_SRC];
   logic [CFG_W-1:0] wdat_m;

   assign wdat_m = wr_data & FIELD_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SRC; i++) cfg_q[i] <= '0;
      end else if (srst) begin
         for (int i = 0; i < NUM_SRC; i++) cfg_q[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (wr_idx == IDX_W'(i)) begin
               case (wr_op)
                  CFG_WRITE: cfg_q[i] <= wdat_m;
                  CFG_SET:   cfg_q[i] <= cfg_q[i] | wdat_m;
                  CFG_CLR:   cfg_q[i] <= cfg_q[i] & ~wdat_m;
                  default:   cfg_q[i] <= cfg_q[i];
               endcase
            end
         end
      end
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_fan
      assign en_o[g]                    = cfg_q[g][EN_BIT];
      assign fiq_o[g]                   = cfg_q[g][FIQ_BIT];
      assign prio_o[g*PRIO_W +: PRIO_W] = cfg_q[g][PRIO_W-1:0];
   end

   assign rd_cfg = cfg_q[rd_idx];

   assert_srst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (en_o == '0 && fiq_o == '0 && prio_o == '0));

   assert_set_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_op == CFG_SET && wr_data[EN_BIT] && !srst) |=> en_o[$past(wr_idx)]);
endmodule

// File: rtl/ivh_arbiter.sv
module ivh_arbiter #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 2,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0]        req,
   input  logic [NUM_SRC*PRIO_W-1:0] prio,
   output logic                      any_o,
   output logic [IDX_W-1:0]          win_o
);
   logic [PRIO_W-1:0] best_p;

   always_comb begin
      any_o  = 1'b0;
      win_o  = '0;
      best_p = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req[i] && (!any_o || prio[i*PRIO_W +: PRIO_W] >= best_p)) begin
            any_o  = 1'b1;
            win_o  = IDX_W'(i);
            best_p = prio[i*PRIO_W +: PRIO_W];
         end
      end
   end

   always_comb begin
      if (any_o) begin
         assert_win_requesting_R6: assert (req[win_o]);
      end
   end
endmodule

// File: rtl/irq_vector_hub.sv
module irq_vector_hub
   import ivh_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 2,
   parameter int DATA_W  = 32,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               bus_wr,
   input  logic [11:0]        bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_o,
   output logic               fiq_o
);
   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_nsrc
      $error("irq_vector_hub: NUM_SRC must lie in 2..32");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio
      $error("irq_vector_hub: PRIO_W must lie in 1..4");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("irq_vector_hub: DATA_W must be 32");
   end

   localparam int SRST_BIT = DATA_W - 1;

   logic              final_en_q;
   logic [DATA_W-1:0] base_q;
   svc_e              state_q;
   logic [IDX_W-1:0]  held_idx_q;

   logic wr_ctrl, wr_base, wr_vect, wr_ack, srst;
   assign wr_ctrl = bus_wr && bus_addr == ADR_CTRL;
   assign wr_base = bus_wr && bus_addr == ADR_BASE;
   assign wr_vect = bus_wr && bus_addr == ADR_VECT;
   assign wr_ack  = bus_wr && bus_addr == ADR_ACK;
   assign srst    = wr_ctrl && bus_wdata[SRST_BIT];

   logic [11:0]      src_off;
   logic             src_hit;
   logic [IDX_W-1:0] src_idx;
   cfg_op_e          cfg_op;
   assign src_off = bus_addr - ADR_SRC0;
   assign src_hit = (bus_addr >= ADR_SRC0) && ({4'd0, src_off[11:4]} < 12'(NUM_SRC));
   assign src_idx = src_off[4 +: IDX_W];
   assign cfg_op  = (bus_wr && src_hit) ? cfg_op_e'(src_off[3:2]) : CFG_NONE;

   logic [NUM_SRC-1:0]        en_v, steer_v;
   logic [NUM_SRC*PRIO_W-1:0] prio_v;
   logic [CFG_W-1:0]          rd_cfg;

   ivh_src_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst    (srst),
      .wr_op   (cfg_op),
      .wr_idx  (src_idx),
      .wr_data (bus_wdata[CFG_W-1:0]),
      .rd_idx  (src_idx),
      .rd_cfg  (rd_cfg),
      .en_o    (en_v),
      .fiq_o   (steer_v),
      .prio_o  (prio_v)
   );

   logic [NUM_SRC-1:0] irq_req;
   logic               any_pend;
   logic [IDX_W-1:0]   win_idx;
   assign irq_req = src_req & en_v & ~steer_v;
   assign fiq_o   = |(src_req & en_v & steer_v);

   ivh_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .req   (irq_req),
      .prio  (prio_v),
      .any_o (any_pend),
      .win_o (win_idx)
   );

   logic entry, ack;
   assign entry = wr_vect && state_q == SV_IDLE && any_pend;
   assign ack   = wr_ack && bus_wdata[0] && state_q == SV_BUSY;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         final_en_q <= 1'b0;
         base_q     <= '0;
         state_q    <= SV_IDLE;
         held_idx_q <= '0;
      end else begin
         if (wr_ctrl) final_en_q <= bus_wdata[0];
         if (wr_base) base_q     <= bus_wdata;
         if (srst) begin
            state_q <= SV_IDLE;
         end else if (entry) begin
            state_q    <= SV_BUSY;
            held_idx_q <= win_idx;
         end else if (ack) begin
            state_q <= SV_IDLE;
         end
      end
   end

   assign irq_o = final_en_q && any_pend && state_q == SV_IDLE;

   logic [IDX_W-1:0]  cur_idx;
   logic [DATA_W-1:0] vector;
   assign cur_idx = (state_q == SV_BUSY) ? held_idx_q : win_idx;
   assign vector  = base_q + (DATA_W'(cur_idx) << 2);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADR_CTRL)      bus_rdata[0] = final_en_q;
      else if (bus_addr == ADR_BASE) bus_rdata    = base_q;
      else if (bus_addr == ADR_VECT) bus_rdata    = vector;
      else if (src_hit)              bus_rdata    = DATA_W'(rd_cfg);
   end

   assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == SV_BUSY |-> !irq_o);

   assert_vector_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SV_BUSY && $past(state_q) == SV_BUSY) |-> $stable(held_idx_q));

   assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> final_en_q);

   assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && bus_wdata[0] && state_q == SV_BUSY) |=> state_q == SV_IDLE);

   assert_fiq_not_vectored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      any_pend |-> !steer_v[win_idx]);
endmodule

// File: tb/tb_irq_vector_hub.sv
module tb_irq_vector_hub;
   localparam int NS = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_req = '0;
   logic          bus_wr = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_o, fiq_o;

   always #5 clk = ~clk;

   irq_vector_hub #(.NUM_SRC(NS), .PRIO_W(2), .DATA_W(32)) dut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .fiq_o(fiq_o)
   );

   typedef struct {
      string       tag;
      logic [31:0] val;
   } item_t;

   item_t exp_q[$];
   item_t act_q[$];
   event  obs_ev;
   int    total = 0;
   int    bad = 0;
   bit    done = 0;

   // monitor: pops expected and observed items and compares them
   initial begin
      forever begin
         @(obs_ev);
         while (act_q.size() > 0 && exp_q.size() > 0) begin
            item_t e, a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            total++;
            if (a.val !== e.val) begin
               bad++;
               $display("FAIL %s actual=%h expected=%h", e.tag, a.val, e.val);
            end
         end
      end
   end

   task automatic push_exp(input string tag, input logic [31:0] v);
      item_t it;
      it.tag = tag; it.val = v;
      exp_q.push_back(it);
   endtask

   task automatic observe(input string tag, input logic [31:0] v);
      item_t it;
      it.tag = tag; it.val = v;
      act_q.push_back(it);
      -> obs_ev;
      #0;
   endtask

   function automatic logic [11:0] sa(input int i, input int sub);
      return 12'(12'h100 + i * 16 + sub * 4);
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic expect_rd(input string tag, input logic [11:0] a, input logic [31:0] e);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = a;
      push_exp(tag, e);
      #1 observe(tag, bus_rdata);
   endtask

   task automatic expect_pins(input string tag, input logic irq_e, input logic fiq_e);
      @(negedge clk);
      push_exp(tag, {30'd0, irq_e, fiq_e});
      #1 observe(tag, {30'd0, irq_o, fiq_o});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_pins("R1 pins", 1'b0, 1'b0);
      expect_rd("R1 ctrl", 12'h000, 32'h0);
      expect_rd("R1 src5", sa(5, 0), 32'h0);

      // R2 field layout and write replace
      wr(sa(3, 0), 32'h13);
      expect_rd("R2 write", sa(3, 0), 32'h13);
      wr(sa(3, 0), 32'hFF);
      expect_rd("R2 mask", sa(3, 0), 32'h33);

      // R3 set / clear aliases
      wr(sa(3, 1), 32'h20);
      expect_rd("R3 set", sa(3, 0), 32'h33);
      wr(sa(3, 2), 32'h10);
      expect_rd("R3 clr", sa(3, 0), 32'h23);
      wr(sa(3, 2), 32'h23);
      expect_rd("R3 clr all", sa(3, 0), 32'h0);

      // R4 gating
      wr(12'h004, 32'h1000);
      wr(sa(2, 0), 32'h10);
      src_req[2] = 1'b1;
      src_req[4] = 1'b1;
      expect_pins("R4 master off", 1'b0, 1'b0);
      wr(12'h000, 32'h1);
      expect_pins("R4 master on", 1'b1, 1'b0);
      src_req[2] = 1'b0;
      expect_pins("R4 disabled src ignored", 1'b0, 1'b0);
      src_req[2] = 1'b1;

      // R5 vector value
      expect_rd("R5 vector", 12'h008, 32'h1008);

      // R6 arbitration
      wr(sa(7, 0), 32'h10);
      src_req[7] = 1'b1;
      expect_rd("R6 tie low index", 12'h008, 32'h1008);
      wr(sa(7, 0), 32'h12);
      expect_rd("R6 higher prio", 12'h008, 32'h101C);
      wr(sa(9, 0), 32'h12);
      src_req[9] = 1'b1;
      expect_rd("R6 tie keeps 7", 12'h008, 32'h101C);

      // R7 entry freezes vector
      wr(12'h008, 32'h0);
      expect_pins("R7 irq drops", 1'b0, 1'b0);
      src_req[7] = 1'b0;
      wr(sa(2, 0), 32'h13);
      expect_rd("R7 vector held", 12'h008, 32'h101C);

      // R8 acknowledge
      wr(12'h00C, 32'h0);
      expect_pins("R8 ack bit0 clear ignored", 1'b0, 1'b0);
      wr(12'h00C, 32'h1);
      expect_pins("R8 irq back", 1'b1, 1'b0);
      expect_rd("R8 new winner", 12'h008, 32'h1008);

      // R9 fiq steering
      wr(sa(2, 1), 32'h20);
      expect_pins("R9 fiq out", 1'b1, 1'b1);
      expect_rd("R9 not vectored", 12'h008, 32'h1024);

      // R6/R7 entry write in the same cycle as a higher request rising
      wr(sa(12, 0), 32'h13);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h0;
      src_req[12] = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      expect_rd("R7 same-cycle latch", 12'h008, 32'h1030);
      wr(12'h00C, 32'h1);
      expect_pins("R8 after concurrent", 1'b1, 1'b1);

      // R10 soft reset
      wr(12'h008, 32'h0);
      wr(12'h000, 32'h8000_0001);
      expect_rd("R10 ctrl bit31 clear", 12'h000, 32'h1);
      expect_rd("R10 src12 cleared", sa(12, 0), 32'h0);
      expect_rd("R10 src2 cleared", sa(2, 0), 32'h0);
      expect_pins("R10 outputs low", 1'b0, 1'b0);
      wr(sa(9, 0), 32'h10);
      expect_pins("R10 service closed", 1'b1, 1'b0);

      #1 -> obs_ev;
      #1;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule